// File: doc/BRIEF.md
# Page-Mode External Memory Bus Controller

This controller runs single external memory cycles for a small 8-bit processor core while page mode is switched on. The core presents a 16-bit address, a cycle kind (code fetch, data read or data write) and a write byte. The controller then drives two 8-bit ports with output enables, an address latch enable, and active-low program-store, read and write strobes. When the cycle ends it returns the fetched or read byte together with a one-clock done pulse.

The controller remembers the upper address byte of the last completed access. If the next access uses the same upper byte, it is a page hit: the external latch already holds that byte, so the controller skips the latch phase and puts out only the lower byte. This makes the cycle shorter. A 2-bit speed select sets the cycle length in clocks. It also picks one of two bus arrangements. In the first, port A carries data and port B carries the address. In the second, port A carries the lower address byte and port B shares the upper address byte with data.

While page mode is off, the controller accepts no requests and forgets the stored page. The conventional multiplexed bus then takes over outside this block.

Top module: `pgbus_ctrl`

## Requirements
- R1: The cycle length in clocks is set by `mode_sel` and the hit/miss result. Select 0 gives 1 on a hit and 2 on a miss. Select 1 gives 2 and 4. Select 2 gives 4 and 8. Select 3 with a code fetch gives 2 and 4.
- R2: With `mode_sel` = 3, a data read or data write takes 4 clocks, whether it is a hit or a miss.
- R3: A cycle is a miss if its upper address byte differs from the upper byte of the last completed access. It is also a miss if no access has completed since reset, or since `page_en` was last low. Otherwise it is a hit.
- R4: On a miss, `ale` is high for the first half of the cycle, and during that half port B drives the upper address byte. On a hit, `ale` stays low for the whole cycle.
- R5: With `mode_sel` 0 to 2, port B is driven for the whole cycle. It carries the upper byte during the latch phase and the lower byte after it. Port A is high-impedance on fetches and reads. On writes, port A drives `req_wdata` while the strobe is low.
- R6: With `mode_sel` = 3, port A drives the lower address byte for the whole cycle. Port B drives the upper byte during the latch phase. After that phase, port B drives `req_wdata` on a write and is high-impedance on a fetch or read.
- R7: The kind encoding is 0 = fetch (`psen_n`), 1 = read (`rd_n`) and 2 = write (`wr_n`). The strobe that matches the kind is low in every clock of the cycle after the latch phase. The other two strobes stay high. No strobe is low while `ale` is high.
- R8: `done` is high for exactly one clock, the clock right after the last bus clock. On a fetch or read, `rdata` then holds the byte sampled as the strobe rises: port A for selects 0 to 2, port B for select 3. A write leaves `rdata` unchanged.
- R9: `req_ready` is high only when `page_en` is high and no cycle is running. A request is taken only when `req_valid` and `req_ready` are both high. A request made while `page_en` is low has no effect on the pins.
- R10: After reset, `ale` and `done` are low, all strobes are high, and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_en | input | 1 | Page mode enable |
| mode_sel | input | 2 | Speed and bus arrangement select |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller can take a request |
| done | output | 1 | Cycle finished pulse |
| rdata | output | 8 | Fetched or read byte |
| pa_in | input | 8 | Port A pin value |
| pa_out | output | 8 | Port A drive value |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin value |
| pb_out | output | 8 | Port B drive value |
| pb_oe | output | 1 | Port B output enable |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program-store strobe, low active |
| rd_n | output | 1 | Read strobe, low active |
| wr_n | output | 1 | Write strobe, low active |

## Verification
Suppose the stored page byte or its valid flag goes wrong. The very next access then gets the wrong hit or miss result. That shows up in the same cycle as an `ale` pulse that should not be there, or one that is missing, and as a cycle that is twice or half its expected length. A wrong cycle counter or wrong half-length shows up in the first affected bus clock, as an early or late strobe or a wrong byte on port B. A fault in the capture path shows up at the `done` pulse, as a wrong `rdata` value.

// File: rtl/pgbus_pkg.sv
package pgbus_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2
    } kind_e;

    // Clocks of a page-hit cycle for each speed select; a miss doubles it.
    function automatic int hit_clocks(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 2;
        endcase
    endfunction

    localparam int SPLIT_DATA_CLOCKS = 4;

endpackage

// File: rtl/pgbus_page.sv
module pgbus_page #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_en,
    input  logic              upd,
    input  logic [PAGE_W-1:0] upd_page,
    input  logic [PAGE_W-1:0] probe_page,
    output logic              miss
);
    typedef struct packed {
        logic              valid;
        logic [PAGE_W-1:0] page;
    } page_s;

    page_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!page_en) begin
            st_d.valid = 1'b0;
        end else if (upd) begin
            st_d.valid = 1'b1;
            st_d.page  = upd_page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miss = !st_q.valid || (st_q.page != probe_page);
endmodule

// File: rtl/pgbus_seq.sv
module pgbus_seq
    import pgbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              miss,
    input  logic [1:0]        mode_sel,
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pa_in,
    input  logic [DATA_W-1:0] pb_in,
    output logic              active,
    output logic              addr_phase,
    output logic              last,
    output logic [1:0]        cur_kind,
    output logic              cur_split,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  len;
        logic [CNT_W-1:0]  half;
        logic [1:0]        kind;
        logic              split;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_s;

    seq_s             st_d, st_q;
    logic [CNT_W-1:0] base_len;
    logic [CNT_W-1:0] new_len;

    assign last = st_q.active && (st_q.cnt == st_q.len - 1'b1);

    always_comb begin
        base_len = CNT_W'(hit_clocks(mode_sel));
        if (mode_sel == 2'd3 && kind != KIND_FETCH) new_len = CNT_W'(SPLIT_DATA_CLOCKS);
        else if (miss)                              new_len = base_len << 1;
        else                                        new_len = base_len;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.active) begin
            if (start) begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
                st_d.len    = new_len;
                st_d.half   = miss ? (new_len >> 1) : '0;
                st_d.kind   = kind;
                st_d.split  = (mode_sel == 2'd3);
                st_d.addr   = addr;
                st_d.wdata  = wdata;
            end
        end else if (last) begin
            st_d.active = 1'b0;
            st_d.done   = 1'b1;
            if (st_q.kind != KIND_WRITE) st_d.rdata = st_q.split ? pb_in : pa_in;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active     = st_q.active;
    assign addr_phase = st_q.active && (st_q.cnt < st_q.half);
    assign cur_kind   = st_q.kind;
    assign cur_split  = st_q.split;
    assign cur_addr   = st_q.addr;
    assign cur_wdata  = st_q.wdata;
    assign done       = st_q.done;
    assign rdata      = st_q.rdata;
endmodule

// File: rtl/pgbus_pins.sv
module pgbus_pins
    import pgbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              active,
    input  logic              addr_phase,
    input  logic [1:0]        kind,
    input  logic              split,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pa_out,
    output logic              pa_oe,
    output logic [DATA_W-1:0] pb_out,
    output logic              pb_oe,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n
);
    logic [DATA_W-1:0] lo_byte, hi_byte;
    logic              strobe_phase, is_write;

    assign lo_byte      = addr[DATA_W-1:0];
    assign hi_byte      = addr[ADDR_W-1 -: DATA_W];
    assign strobe_phase = active && !addr_phase;
    assign is_write     = (kind == KIND_WRITE);

    always_comb begin
        ale    = addr_phase;
        psen_n = !(strobe_phase && kind == KIND_FETCH);
        rd_n   = !(strobe_phase && kind == KIND_READ);
        wr_n   = !(strobe_phase && is_write);
        if (split) begin
            pa_oe  = active;
            pa_out = lo_byte;
            pb_oe  = addr_phase || (active && is_write);
            pb_out = addr_phase ? hi_byte : wdata;
        end else begin
            pa_oe  = strobe_phase && is_write;
            pa_out = wdata;
            pb_oe  = active;
            pb_out = addr_phase ? hi_byte : lo_byte;
        end
    end
endmodule

// File: rtl/pgbus_ctrl.sv
module pgbus_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_en,
    input  logic [1:0]        mode_sel,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic              pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic              pb_oe,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n
);
    localparam int PAGE_W = ADDR_W - DATA_W;

    logic              active, addr_phase, last, miss, start, cur_split;
    logic [1:0]        cur_kind;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    assign req_ready = page_en && !active;
    assign start     = req_valid && req_ready;

    pgbus_page #(.PAGE_W(PAGE_W)) u_page (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_en    (page_en),
        .upd        (last),
        .upd_page   (cur_addr[ADDR_W-1 -: PAGE_W]),
        .probe_page (req_addr[ADDR_W-1 -: PAGE_W]),
        .miss       (miss)
    );

    pgbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .miss       (miss),
        .mode_sel   (mode_sel),
        .kind       (req_kind),
        .addr       (req_addr),
        .wdata      (req_wdata),
        .pa_in      (pa_in),
        .pb_in      (pb_in),
        .active     (active),
        .addr_phase (addr_phase),
        .last       (last),
        .cur_kind   (cur_kind),
        .cur_split  (cur_split),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata),
        .done       (done),
        .rdata      (rdata)
    );

    pgbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .active     (active),
        .addr_phase (addr_phase),
        .kind       (cur_kind),
        .split      (cur_split),
        .addr       (cur_addr),
        .wdata      (cur_wdata),
        .pa_out     (pa_out),
        .pa_oe      (pa_oe),
        .pb_out     (pb_out),
        .pb_oe      (pb_oe),
        .ale        (ale),
        .psen_n     (psen_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n)
    );
endmodule

// File: rtl/pgbus_ctrl_chk.sv
module pgbus_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic page_en,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic pa_oe,
    input logic pb_oe,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n
);
    p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!psen_n, !rd_n, !wr_n}));

    p_no_strobe_in_ale_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (psen_n && rd_n && wr_n));

    p_ale_drives_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> pb_oe);

    p_write_drives_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (pa_oe || pb_oe));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_en && $past(!page_en) && $past(req_ready == 1'b0)) |-> (psen_n && rd_n && wr_n && !ale));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ale && psen_n && rd_n && wr_n));
endmodule

bind pgbus_ctrl pgbus_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .page_en   (page_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .pa_oe     (pa_oe),
    .pb_oe     (pb_oe),
    .ale       (ale),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
);

// File: tb/pgbus_ctrl_bench.sv
module pgbus_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       page_en = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0] req_wdata = 8'h0;
    logic       req_ready, done, pa_oe, pb_oe, ale, psen_n, rd_n, wr_n;
    logic [7:0] rdata, pa_out, pb_out;
    logic [7:0] pa_in = 8'h0;
    logic [7:0] pb_in = 8'h0;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;
    bit   bvalid = 0;
    logic [7:0] bpage = 8'h0;
    logic [7:0] last_rd = 8'h0;

    always #5 clk = ~clk;

    pgbus_ctrl u_pgbus_ctrl (
        .clk(clk), .rst_n(rst_n), .page_en(page_en), .mode_sel(mode_sel),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pb_in(pb_in),
        .pb_out(pb_out), .pb_oe(pb_oe), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_quiet(input string tag);
        check({tag, " ale/strobes"}, {ale, psen_n, rd_n, wr_n}, 4'b0111);
        check({tag, " oe"}, {pa_oe, pb_oe}, 2'b00);
    endtask

    task automatic run_cycle(input logic [1:0] m, input logic [1:0] k,
                             input logic [15:0] a, input logic [7:0] w);
        int len, half;
        logic miss, ap, sp;
        logic [7:0] rd_exp;
        miss = !bvalid || (a[15:8] != bpage);
        if (m == 2'd3 && k != 2'd0) len = 4;
        else begin
            case (m)
                2'd0: len = 1;
                2'd1: len = 2;
                2'd2: len = 4;
                default: len = 2;
            endcase
            if (miss) len = len * 2;
        end
        half = miss ? len / 2 : 0;
        pa_in = a[7:0] ^ 8'hC3;
        pb_in = a[7:0] + a[15:8] + 8'd1;
        rd_exp = (m == 2'd3) ? pb_in : pa_in;
        mode_sel = m; req_kind = k; req_addr = a; req_wdata = w; req_valid = 1'b1;
        check("R9 ready when idle", {31'd0, req_ready}, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~a;
        req_wdata = ~w;
        for (int i = 0; i < len; i++) begin
            if (i > 0) @(negedge clk);
            ap = (i < half);
            sp = !ap;
            check(miss ? "R4 ale on miss" : "R4 no ale on hit", {31'd0, ale}, {31'd0, ap});
            check("R7 strobes", {psen_n, rd_n, wr_n},
                  {!(sp && k == 2'd0), !(sp && k == 2'd1), !(sp && k == 2'd2)});
            check((m == 2'd3 && k != 2'd0) ? "R2 no early done" : "R1 no early done",
                  {30'd0, done, req_ready}, 0);
            if (m != 2'd3) begin
                check("R5 pb_oe", {31'd0, pb_oe}, 1);
                check("R5 pb_out", pb_out, ap ? a[15:8] : a[7:0]);
                check("R5 pa_oe", {31'd0, pa_oe}, {31'd0, sp && k == 2'd2});
                if (pa_oe) check("R5 pa_out", pa_out, w);
            end else begin
                check("R6 pa_oe", {31'd0, pa_oe}, 1);
                check("R6 pa_out", pa_out, a[7:0]);
                check("R6 pb_oe", {31'd0, pb_oe}, {31'd0, ap || k == 2'd2});
                if (pb_oe) check("R6 pb_out", pb_out, ap ? a[15:8] : w);
            end
        end
        @(negedge clk);
        check((m == 2'd3 && k != 2'd0) ? "R2 length" : "R1 length", {31'd0, done}, 1);
        if (k != 2'd2) last_rd = rd_exp;
        check("R8 rdata", rdata, last_rd);
        check_quiet("R10 idle after cycle");
        bvalid = 1;
        bpage = a[15:8];
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check_quiet("R10 reset");
        check("R10 done reset", {31'd0, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 not ready when disabled", {31'd0, req_ready}, 0);
        page_en = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 3; k++) begin
                for (int j = 0; j < 3; j++) begin
                    logic [7:0] hi, lo;
                    hi = (j == 2) ? 8'h40 + 8'(m * 4 + k) : 8'h20 + 8'(m * 4 + k);
                    lo = 8'(j * 37 + k + m * 11);
                    run_cycle(2'(m), 2'(k), {hi, lo}, 8'h90 + 8'(m * 3 + k + j));
                end
            end
        end
        // back-to-back hits in the fastest select
        run_cycle(2'd0, 2'd0, {bpage, 8'h01}, 8'h00);
        run_cycle(2'd0, 2'd1, {bpage, 8'h02}, 8'h00);
        // disabled: request ignored, page forgotten
        page_en = 1'b0;
        req_valid = 1'b1; req_kind = 2'd0; req_addr = {bpage, 8'h05};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_quiet("R9 ignored while disabled");
            check("R9 no ready/done", {30'd0, req_ready, done}, 0);
        end
        req_valid = 1'b0;
        bvalid = 0;
        page_en = 1'b1;
        @(negedge clk);
        run_cycle(2'd1, 2'd0, {bpage, 8'h06}, 8'h00);   // R3 first after enable misses
        run_cycle(2'd1, 2'd0, {bpage, 8'h07}, 8'h00);   // R3 same page hits
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired, actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule